// File: doc/BRIEF.md
# Bus Slave Front End with Posted Write Queue

This block is the parallel-bus side of a bridge that carries traffic onto a slow serial link. It acts as an AHB-Lite slave. It takes single transfers and bursts. Each write is stored, with its address, in a small internal queue and completes at once. This frees the bus for other masters while the serial engine drains the queue at its own pace. A stall on a write happens only when the queue is full.

Reads cannot be posted, and split responses are not offered, so a read holds the bus. The slave raises a read request toward the serial engine and keeps its ready output low until that engine acknowledges with the data. The slave then completes the transfer one cycle later, with the captured word on the read-data bus.

Transfers that are not requesting work (idle or busy) complete in zero wait states. Transfers wider than a 32-bit word get the protocol's two-cycle error response. The serial engine sees a valid/pop interface on the queue head and a request/acknowledge pair for reads.

Top module: `ahb_posted_slave`

## Requirements
- R1: After reset the ready output is high, the response is OKAY (0), the queue is empty (`wq_valid` low) and `rd_req` is low.
- R2: An address phase with transfer type IDLE (2'b00) or BUSY (2'b01), or with `bus_sel` low, is followed by a zero-wait OKAY cycle and pushes nothing into the queue.
- R3: An address phase is taken only when `bus_sel`, `bus_ready_in` and a transfer type of NONSEQ (2'b10) or SEQ (2'b11) are all true. The following cycle is its data phase.
- R4: A write of size byte (3'b000), halfword (3'b001) or word (3'b010) whose data phase finds room in the queue completes with ready high. It stores the captured address and the data-phase `bus_wdata`.
- R5: The queue holds 4 entries and presents them at `wq_addr`/`wq_data` in arrival order. An entry is removed in each cycle where `wq_pop` and `wq_valid` are both high.
- R6: A write data phase that finds the queue full holds ready low, including the cycle in which an entry is popped. It completes with ready high in the following cycle.
- R7: A read data phase drives `rd_req` high with the captured address on `rd_addr`, and holds ready low until `rd_ack`. In the next cycle ready is high, `rd_req` is low, and `bus_rdata` equals the `rd_data` value sampled with `rd_ack`.
- R8: A transfer with size above word (3'b011 or more) gets a first cycle with response ERROR (1) and ready low, then a second cycle with response ERROR and ready high. It neither pushes nor requests a read.
- R9: A burst of back-to-back NONSEQ/SEQ writes into a queue with room completes every beat with no wait state.
- R10: An address phase presented while `bus_ready_in` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Slave select |
| bus_addr | input | 7 | Address-phase address |
| bus_trans | input | 2 | Transfer type |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 3 | Transfer size |
| bus_ready_in | input | 1 | Bus-wide ready, previous transfer done |
| bus_wdata | input | 32 | Write data (data phase) |
| bus_ready_out | output | 1 | This slave's ready |
| bus_resp | output | 1 | 0 = OKAY, 1 = ERROR |
| bus_rdata | output | 32 | Read data |
| wq_valid | output | 1 | Queue head is valid |
| wq_addr | output | 7 | Address of queue head |
| wq_data | output | 32 | Data of queue head |
| wq_pop | input | 1 | Serial engine takes the head |
| rd_req | output | 1 | Read request to serial engine |
| rd_addr | output | 7 | Read address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 32 | Read data from serial engine |

## Verification
The hardest situation to reach from the ports is a write data phase that meets a full queue while the serial engine pops in that same cycle. The stall must persist for that cycle and release exactly one cycle later. The stimulus gets there with a four-beat burst that fills the queue, followed by a fifth write. The pop is then held back for several cycles before a single pop is issued, and the queue is drained to confirm that the fifth entry landed last. The error path is checked in both of its cycles, and the queue is inspected afterward to confirm that nothing was pushed.

// File: rtl/bridge_fe_pkg.sv
// Shared constants and phase encoding for the bus front end.
// Assumes the standard transfer-type and size encodings of the bus.
package bridge_fe_pkg;
    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;
    localparam logic [2:0] SZ_WORD   = 3'b010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WRITE,
        PH_READ_WAIT,
        PH_READ_DONE,
        PH_ERR_FIRST,
        PH_ERR_SECOND
    } phase_t;
endpackage

// File: rtl/wq_fifo.sv
// Posted-write queue: DEPTH entries of WIDTH bits, first in first out.
// Assumes push is only requested when not full; head is read combinationally.
module wq_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 39
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write: place the new entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/fe_ctrl.sv
// Transfer decoder and wait-state generator for the bus slave.
// Tracks the pending data phase, drives ready/response, requests queue
// pushes and serial reads. Assumes bus_ready_in reflects the bus-wide ready.
module fe_ctrl
    import bridge_fe_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_trans,
    input  logic              bus_write,
    input  logic [2:0]        bus_size,
    input  logic              bus_ready_in,
    input  logic              q_full,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              ready_out,
    output logic              resp,
    output logic [DATA_W-1:0] rdata,
    output logic              push,
    output logic              rd_req,
    output logic [ADDR_W-1:0] cap_addr
);
    phase_t phase, phase_nxt;
    logic   accept;
    logic   size_bad;

    assign accept   = bus_sel && bus_ready_in &&
                      (bus_trans == TR_NONSEQ || bus_trans == TR_SEQ);
    assign size_bad = (bus_size > SZ_WORD);

    // Output decode for the current data phase.
    always_comb begin
        ready_out = 1'b1;
        resp      = 1'b0;
        push      = 1'b0;
        rd_req    = 1'b0;
        unique case (phase)
            PH_WRITE: begin
                ready_out = !q_full;
                push      = !q_full;
            end
            PH_READ_WAIT: begin
                ready_out = 1'b0;
                rd_req    = 1'b1;
            end
            PH_ERR_FIRST: begin
                ready_out = 1'b0;
                resp      = 1'b1;
            end
            PH_ERR_SECOND: resp = 1'b1;
            default: ;
        endcase
    end

    // Next data phase: a completing cycle may admit a new address phase.
    always_comb begin
        phase_nxt = phase;
        if (ready_out) begin
            if (!accept)        phase_nxt = PH_IDLE;
            else if (size_bad)  phase_nxt = PH_ERR_FIRST;
            else if (bus_write) phase_nxt = PH_WRITE;
            else                phase_nxt = PH_READ_WAIT;
        end else if (phase == PH_ERR_FIRST) begin
            phase_nxt = PH_ERR_SECOND;
        end else if (phase == PH_READ_WAIT && rd_ack) begin
            phase_nxt = PH_READ_DONE;
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nxt;
    end

    // Address capture on an admitted address phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cap_addr <= '0;
        else if (ready_out && accept) cap_addr <= bus_addr;
    end

    // Read data capture when the serial engine acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n)                               rdata <= '0;
        else if (phase == PH_READ_WAIT && rd_ack) rdata <= rd_data;
    end
endmodule

// File: rtl/ahb_posted_slave.sv
// Bus slave front end of a serial bridge: writes are posted to a queue,
// reads stall until the serial engine returns data. Assumes one outstanding
// transfer per the bus pipelining rules; split responses are not used.
module ahb_posted_slave #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int Q_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_trans,
    input  logic              bus_write,
    input  logic [2:0]        bus_size,
    input  logic              bus_ready_in,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready_out,
    output logic              bus_resp,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wq_valid,
    output logic [ADDR_W-1:0] wq_addr,
    output logic [DATA_W-1:0] wq_data,
    input  logic              wq_pop,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data
);
    localparam int ENTRY_W = ADDR_W + DATA_W;

    logic               q_full, q_empty, q_push;
    logic [ENTRY_W-1:0] q_head;
    logic [ADDR_W-1:0]  cap_addr;

    fe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_addr     (bus_addr),
        .bus_trans    (bus_trans),
        .bus_write    (bus_write),
        .bus_size     (bus_size),
        .bus_ready_in (bus_ready_in),
        .q_full       (q_full),
        .rd_ack       (rd_ack),
        .rd_data      (rd_data),
        .ready_out    (bus_ready_out),
        .resp         (bus_resp),
        .rdata        (bus_rdata),
        .push         (q_push),
        .rd_req       (rd_req),
        .cap_addr     (cap_addr)
    );

    wq_fifo #(.DEPTH(Q_DEPTH), .WIDTH(ENTRY_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data ({cap_addr, bus_wdata}),
        .pop       (wq_pop),
        .head      (q_head),
        .full      (q_full),
        .empty     (q_empty)
    );

    assign wq_valid = !q_empty;
    assign wq_addr  = q_head[ENTRY_W-1:DATA_W];
    assign wq_data  = q_head[DATA_W-1:0];
    assign rd_addr  = cap_addr;
endmodule

// File: rtl/ahb_posted_slave_chk.sv
// Protocol checker bound to the front end; observes ports only.
module ahb_posted_slave_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ready_out,
    input logic              bus_resp,
    input logic              wq_valid,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack
);
    // R1: the cycle after reset shows an idle, ready slave.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (bus_ready_out && !bus_resp && !wq_valid && !rd_req));

    // R8: the first error cycle is always followed by the second.
    assert_err_two_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_resp && !bus_ready_out) |=> (bus_resp && bus_ready_out));

    // R8: a completing error cycle is always preceded by the stalled one.
    assert_err_preceded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_resp && bus_ready_out) |-> $past(bus_resp && !bus_ready_out));

    // R6: an OKAY stall outside a read only happens with a non-empty queue.
    assert_stall_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready_out && !bus_resp && !rd_req) |-> wq_valid);

    // R7: a pending read holds request and address until acknowledged.
    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R7: the bus is stalled while a read is outstanding.
    assert_rd_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (!bus_ready_out && !bus_resp));
endmodule

bind ahb_posted_slave ahb_posted_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_ready_out (bus_ready_out),
    .bus_resp      (bus_resp),
    .wq_valid      (wq_valid),
    .rd_req        (rd_req),
    .rd_addr       (rd_addr),
    .rd_ack        (rd_ack)
);

// File: tb/ahb_posted_slave_tb.sv
module ahb_posted_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic [6:0]  addr = '0;
    logic [1:0]  trans = 2'b00;
    logic        wr = 1'b0;
    logic [2:0]  size = 3'b010;
    logic        blk = 1'b0;
    logic        rin;
    logic [31:0] wdata = '0;
    logic        rout, resp;
    logic [31:0] rdata;
    logic        qv;
    logic [6:0]  qa;
    logic [31:0] qd;
    logic        pop = 1'b0;
    logic        rreq;
    logic [6:0]  raddr;
    logic        rack = 1'b0;
    logic [31:0] rdin = '0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    assign rin = rout & ~blk;

    ahb_posted_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_addr(addr),
        .bus_trans(trans), .bus_write(wr), .bus_size(size),
        .bus_ready_in(rin), .bus_wdata(wdata), .bus_ready_out(rout),
        .bus_resp(resp), .bus_rdata(rdata), .wq_valid(qv), .wq_addr(qa),
        .wq_data(qd), .wq_pop(pop), .rd_req(rreq), .rd_addr(raddr),
        .rd_ack(rack), .rd_data(rdin)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic addr_phase(input logic [1:0] t, input logic w, input logic [2:0] s,
                              input logic [6:0] a);
        sel = 1'b1; trans = t; wr = w; size = s; addr = a;
    endtask

    task automatic go_idle();
        sel = 1'b0; trans = 2'b00; wr = 1'b0; size = 3'b010;
    endtask

    // Vector: trans[47:46] write[45] size[44:42] addr[41:35] wdata[34:3]
    //         exp_ready[2] exp_resp[1] exp_push[0] (first data-phase cycle)
    localparam int NV = 6;
    localparam logic [47:0] VEC [NV] = '{
        {2'b10, 1'b1, 3'b010, 7'h11, 32'hA5A5_0001, 1'b1, 1'b0, 1'b1},
        {2'b00, 1'b1, 3'b010, 7'h12, 32'hDEAD_0002, 1'b1, 1'b0, 1'b0},
        {2'b01, 1'b1, 3'b010, 7'h13, 32'hDEAD_0003, 1'b1, 1'b0, 1'b0},
        {2'b10, 1'b1, 3'b001, 7'h22, 32'h0000_BEEF, 1'b1, 1'b0, 1'b1},
        {2'b10, 1'b1, 3'b011, 7'h33, 32'hDEAD_0005, 1'b0, 1'b1, 1'b0},
        {2'b11, 1'b1, 3'b000, 7'h7F, 32'h0000_0077, 1'b1, 1'b0, 1'b1}
    };

    logic [6:0]  exp_a [8];
    logic [31:0] exp_d [8];
    int          n_exp;

    task automatic drain(input string tag);
        for (int i = 0; i < n_exp; i++) begin
            chk({tag, " valid"}, 32'(qv), 32'd1);
            chk({tag, " addr"}, 32'(qa), 32'(exp_a[i]));
            chk({tag, " data"}, qd, exp_d[i]);
            pop = 1'b1;
            step();
        end
        pop = 1'b0;
        step();
        chk({tag, " empty"}, 32'(qv), 32'd0);
        n_exp = 0;
    endtask

    initial begin
        n_exp = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ready after reset", 32'(rout), 32'd1);
        chk("R1 resp after reset", 32'(resp), 32'd0);
        chk("R1 queue empty", 32'(qv), 32'd0);
        chk("R1 no read req", 32'(rreq), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2 (IDLE/BUSY), R4 sizes, R8 error.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            addr_phase(VEC[v][47:46], VEC[v][45], VEC[v][44:42], VEC[v][41:35]);
            step();
            wdata = VEC[v][34:3];
            go_idle();
            #1;
            chk($sformatf("R2/R4/R8 vec%0d ready", v), 32'(rout), 32'(VEC[v][2]));
            chk($sformatf("R2/R4/R8 vec%0d resp", v), 32'(resp), 32'(VEC[v][1]));
            if (VEC[v][1]) begin
                chk("R8 no read during error", 32'(rreq), 32'd0);
                step();
                chk("R8 second cycle ready", 32'(rout), 32'd1);
                chk("R8 second cycle resp", 32'(resp), 32'd1);
            end
            if (VEC[v][0]) begin
                exp_a[n_exp] = VEC[v][41:35];
                exp_d[n_exp] = VEC[v][34:3];
                n_exp++;
            end
        end
        step();
        chk("R2 idle OKAY afterwards", 32'(resp), 32'd0);
        drain("R5 table order");

        // R2: unselected write must not push.
        @(negedge clk);
        addr_phase(2'b10, 1'b1, 3'b010, 7'h40);
        sel = 1'b0;
        step();
        wdata = 32'h1234_5678;
        go_idle();
        #1;
        chk("R2 unselected ready", 32'(rout), 32'd1);
        step();
        chk("R2 unselected no push", 32'(qv), 32'd0);

        // R10: address phase with ready_in low is ignored.
        @(negedge clk);
        blk = 1'b1;
        addr_phase(2'b10, 1'b1, 3'b010, 7'h41);
        step();
        blk = 1'b0;
        wdata = 32'h5555_AAAA;
        go_idle();
        step();
        chk("R10 ignored phase no push", 32'(qv), 32'd0);
        chk("R10 ignored phase no read", 32'(rreq), 32'd0);

        // R9 burst fills queue; R6 full stall across pop cycle.
        @(negedge clk);
        for (int b = 0; b < 5; b++) begin
            addr_phase((b == 0 || b == 4) ? 2'b10 : 2'b11, 1'b1, 3'b010, 7'(8'h50 + b));
            step();
            if (b > 0 || b == 0) begin
                wdata = 32'hB000_0000 + b;
                exp_a[n_exp] = 7'(8'h50 + b);
                exp_d[n_exp] = 32'hB000_0000 + b;
                n_exp++;
            end
            if (b < 4) begin
                #1;
                chk($sformatf("R9 burst beat %0d no wait", b), 32'(rout), 32'd1);
            end
        end
        go_idle();
        #1;
        chk("R6 full stall", 32'(rout), 32'd0);
        step();
        chk("R6 full stall held", 32'(rout), 32'd0);
        step();
        chk("R6 full stall held 2", 32'(rout), 32'd0);
        chk("R6 full stall OKAY", 32'(resp), 32'd0);
        pop = 1'b1;
        #1;
        chk("R6 stall in pop cycle", 32'(rout), 32'd0);
        step();
        pop = 1'b0;
        #1;
        chk("R6 completes after pop", 32'(rout), 32'd1);
        // head was popped once; shift expectations
        for (int i = 0; i < 4; i++) begin
            exp_a[i] = exp_a[i+1];
            exp_d[i] = exp_d[i+1];
        end
        n_exp = 4;
        step();
        drain("R5 fifo order after stall");

        // R7: read stalls until acknowledge.
        @(negedge clk);
        addr_phase(2'b10, 1'b0, 3'b010, 7'h2C);
        step();
        go_idle();
        #1;
        chk("R7 read request", 32'(rreq), 32'd1);
        chk("R7 read addr", 32'(raddr), 32'h2C);
        chk("R7 read stall", 32'(rout), 32'd0);
        step();
        step();
        chk("R7 read still stalled", 32'(rout), 32'd0);
        rack = 1'b1;
        rdin = 32'hC0FF_EE11;
        #1;
        chk("R7 stall in ack cycle", 32'(rout), 32'd0);
        step();
        rack = 1'b0;
        rdin = 32'h0;
        #1;
        chk("R7 read done ready", 32'(rout), 32'd1);
        chk("R7 read data", rdata, 32'hC0FF_EE11);
        chk("R7 request dropped", 32'(rreq), 32'd0);
        chk("R3 read did not push", 32'(qv), 32'd0);

        // R3: SEQ with select is taken as a transfer (read path).
        @(negedge clk);
        addr_phase(2'b11, 1'b0, 3'b000, 7'h01);
        step();
        go_idle();
        #1;
        chk("R3 SEQ read accepted", 32'(rreq), 32'd1);
        rack = 1'b1;
        rdin = 32'h0000_0042;
        step();
        rack = 1'b0;
        #1;
        chk("R3 SEQ read data", rdata, 32'h0000_0042);

        step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule